// File: doc/BRIEF.md
# Fetch Program Counter Sequencer

This block holds the 32-bit program counter of a fetch stage and picks the next fetch address on every enabled clock. It looks at the instruction word that has just been fetched. The word's top six bits give the opcode, which sets the format class. Together with a branch-condition bit from an external comparator, the opcode chooses one of three next addresses:

- the sequential address PC+4;
- a PC-relative branch target;
- an absolute jump target, formed by splicing the word's 26-bit target field under the upper four bits of PC+4.

The surrounding pipeline uses the current PC to address instruction memory. It uses the format class to steer operand decode. When the word is a jump-and-link, it writes the link address into the register file. Instruction storage, register reads, the ALU and register-indirect jumps all live outside this block.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the PC to 0x00400000, whatever the value of `fetchEn`.
- R2: `fmtClass` is decoded combinationally from opcode bits [31:26] of `instrWord`. Opcode 0 gives 2'd0 (R class), opcodes 2 and 3 give 2'd2 (J class), and every other opcode gives 2'd1 (I class).
- R3: Opcode 2 is an unconditional jump. The next PC is {(PC+4)[31:28], instrWord[25:0], 2'b00}, and `condTrue` has no effect on it.
- R4: Opcode 3 jumps to the same target as opcode 2. While opcode 3 is present, `linkValid` is high, and at all times `linkAddr` equals PC+4. For every other opcode, `linkValid` is low.
- R5: Opcodes 4 and 5 are conditional branches. When `condTrue` is high, the next PC is PC+4 plus the sign-extended instrWord[15:0] shifted left by two. For example, a branch with offset 3 at 0x00400008 goes to 0x00400018, and offset 0xFFFF goes to PC.
- R6: For opcodes 4 and 5 with `condTrue` low, the next PC is PC+4.
- R7: For every opcode other than 2, 3, 4 and 5, the next PC is PC+4, whatever the value of `condTrue`.
- R8: While `fetchEn` is low and `rst` is low, the PC keeps its value across the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetchEn | input | 1 | Allows the PC to advance at this edge |
| instrWord | input | 32 | Instruction word fetched at the current PC |
| condTrue | input | 1 | Branch condition from the external comparator |
| pcOut | output | 32 | Current program counter |
| fmtClass | output | 2 | Format class: 0 = R, 1 = I, 2 = J |
| linkAddr | output | 32 | PC+4, the value to write for a jump-and-link |
| linkValid | output | 1 | High while the word is a jump-and-link |

## Verification
Two kinds of collision are provoked. In the first, reset and fetch enable are high in the same cycle while the instruction word would send the PC somewhere else; the PC must still land on 0x00400000. In the second, a jump opcode arrives while the branch condition is high; the PC must take the jump target and never a branch-offset sum. The bench sweeps all 64 opcodes, with both values of the condition bit, over pseudo-random target and offset fields. It works out each next PC arithmetically from the rules above.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [1:0] {
    FMT_R = 2'd0,
    FMT_I = 2'd1,
    FMT_J = 2'd2
  } fmtClass_e;

  typedef struct packed {
    logic seqStep;
    logic brTake;
    logic jmpTake;
    logic linkEn;
  } pcStrobes_t;
endpackage

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pc_seq_pkg::*;
#(
  parameter int OPC_W = 6
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             condTrue,
  output pcStrobes_t       strobes,
  output fmtClass_e        fmtClass
);
  localparam logic [OPC_W-1:0] OPC_RTYPE = OPC_W'(0);
  localparam logic [OPC_W-1:0] OPC_JMP   = OPC_W'(2);
  localparam logic [OPC_W-1:0] OPC_JAL   = OPC_W'(3);
  localparam logic [OPC_W-1:0] OPC_BEQ   = OPC_W'(4);
  localparam logic [OPC_W-1:0] OPC_BNE   = OPC_W'(5);

  logic isJump;
  logic isBranch;

  always_comb begin
    isJump   = (opcode == OPC_JMP) || (opcode == OPC_JAL);
    isBranch = (opcode == OPC_BEQ) || (opcode == OPC_BNE);
  end

  always_comb begin
    if (opcode == OPC_RTYPE) fmtClass = FMT_R;
    else if (isJump)         fmtClass = FMT_J;
    else                     fmtClass = FMT_I;
  end

  always_comb begin
    strobes.jmpTake = isJump;
    strobes.brTake  = isBranch && condTrue;
    strobes.seqStep = !isJump && !(isBranch && condTrue);
    strobes.linkEn  = (opcode == OPC_JAL);
  end

  // R3/R5/R6: exactly one next-address source is selected
  always_comb begin
    if (!$isunknown({opcode, condTrue})) begin
      p_one_source_r5: assert ($onehot({strobes.seqStep, strobes.brTake, strobes.jmpTake}));
      p_link_is_jump_r4: assert (!strobes.linkEn || strobes.jmpTake);
    end
  end
endmodule

// File: rtl/pc_dpath.sv
module pc_dpath
  import pc_seq_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              IMM_W      = 16,
  parameter int              TGT_W      = 26,
  parameter logic [ADDR_W-1:0] START_ADDR = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetchEn,
  input  pcStrobes_t        strobes,
  input  logic [IMM_W-1:0]  immField,
  input  logic [TGT_W-1:0]  tgtField,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] linkAddr
);
  localparam int          SEG_W   = ADDR_W - TGT_W - 2;
  localparam int          EXT_W   = ADDR_W - IMM_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] pcPlus4;
  logic [ADDR_W-1:0] brOffset;
  logic [ADDR_W-1:0] brTarget;
  logic [ADDR_W-1:0] jmpTarget;
  logic [ADDR_W-1:0] pcNext;

  always_comb begin
    pcPlus4   = pcQ + STEP;
    brOffset  = {{EXT_W{immField[IMM_W-1]}}, immField, 2'b00};
    brTarget  = pcPlus4 + brOffset;
    jmpTarget = {pcPlus4[ADDR_W-1 -: SEG_W], tgtField, 2'b00};
  end

  always_comb begin
    unique case (1'b1)
      strobes.jmpTake: pcNext = jmpTarget;
      strobes.brTake:  pcNext = brTarget;
      default:         pcNext = pcPlus4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          pcQ <= START_ADDR;
    else if (fetchEn) pcQ <= pcNext;
  end

  assign pcOut    = pcQ;
  assign linkAddr = pcPlus4;

  p_reset_start_r1: assert property (@(posedge clk)
    $past(rst) |-> pcQ == START_ADDR);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !fetchEn |=> pcQ == $past(pcQ));

  p_seq_step_r7: assert property (@(posedge clk) disable iff (rst)
    (fetchEn && strobes.seqStep) |=> pcQ == $past(pcQ) + STEP);

  p_jump_region_r3: assert property (@(posedge clk) disable iff (rst)
    (fetchEn && strobes.jmpTake) |=>
      (pcQ[1:0] == 2'b00) && (pcQ[ADDR_W-1 -: SEG_W] == $past(pcPlus4[ADDR_W-1 -: SEG_W])));

  p_branch_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    (fetchEn && strobes.brTake) |=> pcQ[1:0] == $past(pcQ[1:0]));
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] START_ADDR = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetchEn,
  input  logic [31:0]       instrWord,
  input  logic              condTrue,
  output logic [ADDR_W-1:0] pcOut,
  output logic [1:0]        fmtClass,
  output logic [ADDR_W-1:0] linkAddr,
  output logic              linkValid
);
  localparam int OPC_W = 6;
  localparam int IMM_W = 16;
  localparam int TGT_W = 26;

  pcStrobes_t strobes;
  fmtClass_e  fmtEnum;

  pc_ctrl #(.OPC_W(OPC_W)) i_ctrl (
    .opcode   (instrWord[31 -: OPC_W]),
    .condTrue (condTrue),
    .strobes  (strobes),
    .fmtClass (fmtEnum)
  );

  pc_dpath #(
    .ADDR_W     (ADDR_W),
    .IMM_W      (IMM_W),
    .TGT_W      (TGT_W),
    .START_ADDR (START_ADDR)
  ) i_dpath (
    .clk      (clk),
    .rst      (rst),
    .fetchEn  (fetchEn),
    .strobes  (strobes),
    .immField (instrWord[IMM_W-1:0]),
    .tgtField (instrWord[TGT_W-1:0]),
    .pcOut    (pcOut),
    .linkAddr (linkAddr)
  );

  assign fmtClass  = fmtEnum;
  assign linkValid = strobes.linkEn;
endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetchEn = 1'b0;
  logic [31:0] instrWord = 32'h0;
  logic        condTrue = 1'b0;
  logic [31:0] pcOut;
  logic [1:0]  fmtClass;
  logic [31:0] linkAddr;
  logic        linkValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] expPc;
  logic [31:0] lfsr = 32'h1234_5678;

  always #10 clk = ~clk;

  pc_sequencer i_pc_sequencer (
    .clk(clk), .rst(rst), .fetchEn(fetchEn), .instrWord(instrWord),
    .condTrue(condTrue), .pcOut(pcOut), .fmtClass(fmtClass),
    .linkAddr(linkAddr), .linkValid(linkValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextPc(input logic [31:0] pc, input logic [31:0] w, input logic c);
    logic [31:0] p4;
    logic [5:0]  op;
    p4 = pc + 32'd4;
    op = w[31:26];
    if (op == 6'd2 || op == 6'd3) return {p4[31:28], w[25:0], 2'b00};
    if ((op == 6'd4 || op == 6'd5) && c) return p4 + {{14{w[15]}}, w[15:0], 2'b00};
    return p4;
  endfunction

  function automatic logic [1:0] expClass(input logic [5:0] op);
    if (op == 6'd0) return 2'd0;
    if (op == 6'd2 || op == 6'd3) return 2'd2;
    return 2'd1;
  endfunction

  // starts and ends at a falling edge
  task automatic step(input logic [31:0] w, input logic c, input logic en, input logic r, input string req);
    instrWord = w; condTrue = c; fetchEn = en; rst = r;
    #1;
    check("R2 class", {30'd0, fmtClass}, {30'd0, expClass(w[31:26])});
    check("R4 link valid", {31'd0, linkValid}, {31'd0, w[31:26] == 6'd3});
    check("R4 link addr", linkAddr, expPc + 32'd4);
    @(posedge clk);
    if (r) expPc = 32'h0040_0000;
    else if (en) expPc = nextPc(expPc, w, c);
    @(negedge clk);
    check(req, pcOut, expPc);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    expPc = 32'h0040_0000;
    check("R1 reset value", pcOut, 32'h0040_0000);
    // R5 directed: two sequential steps then branch offset 3 at 0x00400008
    step(32'h0000_1025, 1'b0, 1'b1, 1'b0, "R7 sequential");
    step(32'h0005_402A, 1'b1, 1'b1, 1'b0, "R7 sequential cond ignored");
    step(32'h1100_0003, 1'b1, 1'b1, 1'b0, "R5 branch offset 3");
    check("R5 literal target", pcOut, 32'h0040_0018);
    step(32'h1100_FFFF, 1'b1, 1'b1, 1'b0, "R5 negative offset");
    check("R5 offset -1 stays", pcOut, 32'h0040_0018);
    step(32'h1100_0040, 1'b0, 1'b1, 1'b0, "R6 branch not taken");
    step(32'h0810_0001, 1'b1, 1'b1, 1'b0, "R3 jump with cond high");
    check("R3 literal target", pcOut, 32'h0040_0004);
    step(32'h0C00_0100, 1'b0, 1'b1, 1'b0, "R4 jump and link");
    step(32'h1400_0010, 1'b1, 1'b0, 1'b0, "R8 hold while disabled");
    step(32'h0800_0123, 1'b0, 1'b1, 1'b1, "R1 reset beats jump");
    // sweep every opcode with both condition values
    for (int op = 0; op < 64; op++) begin
      for (int c = 0; c < 2; c++) begin
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        step({op[5:0], lfsr[25:0]}, c[0], 1'b1, 1'b0, "R3 R5 R6 R7 sweep");
        step({op[5:0], lfsr[31:6]}, c[0], 1'b0, 1'b0, "R8 sweep hold");
      end
    end
    step(32'h1000_0001, 1'b1, 1'b1, 1'b1, "R1 reset beats branch");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule